// File: doc/BRIEF.md
# Flow-Control Pause Interval Timer

This block times the hold-off interval that a received flow-control (pause) frame asks the transmitter to observe. An upstream receive filter delivers a one-cycle strobe with the frame's 16-bit pause quanta. It also delivers two flags saying how the frame's destination was qualified: the reserved flow-control multicast address 01-80-C2-00-00-01, or a match on a programmed address. When reception is enabled and the frame qualifies, the timer loads the quanta. It then counts the quanta down once per slot time, using an external `slot_tick` pulse that fires once every 512 bit times. While the interval runs it asserts `tx_hold` to the transmit MAC.

A single 32-bit control/status word gives software its view of the timer. Software writes the enables and can start an interval by hand with a load bit. It reads back the live counter value, the active and received flags and the auto-negotiated enable. An interval started by hand is refused while a frame-driven or manual interval is still running. Clearing the manual enable bit while it is set aborts any running interval.

Top module: `pause_timer_top`

## Requirements
- R1: After a synchronous reset the read word is 0x00000000 and `tx_hold` is 0.
- R2: A frame is taken only when reception is enabled, which is true when control bit 0 (manual enable) is 1 or the `neg_en` input is 1. When both are 0 the frame changes neither the count nor the flags.
- R3: A frame addressed to the reserved multicast qualifies only when control bit 1 is set. A frame with a programmed-address hit qualifies only when control bit 2 is set. A frame that fails both tests is ignored.
- R4: A taken frame with a nonzero quanta loads the count (read bits 31:16) on the next edge and sets the active flag (read bit 8) and the received flag (read bit 9). `tx_hold` equals the active flag.
- R5: While active, the count drops by exactly one on each clock with `slot_tick` high, and holds on every other clock.
- R6: The tick that takes the count from 1 to 0 clears the active and received flags on the same edge.
- R7: A taken frame with quanta 0 ends any interval at once: the count becomes 0 and both flags clear.
- R8: A taken frame during an interval reloads the count with its new quanta.
- R9: A write with bit 3 (load) set loads bits 31:16 of the written word as the count and sets active, leaving received clear. This happens only when active and received are both 0; otherwise the count and flags are unchanged by it.
- R10: The load bit (bit 3) always reads 0. Read bit 10 shows `neg_en`. Bits 2:0 read back the last written enables.
- R11: A write that clears bit 0 while bit 0 is set ends any interval at once (count 0, flags clear). A write that keeps bit 0 set does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_tick | input | 1 | One-cycle pulse per slot time (512 bit times) |
| neg_en | input | 1 | Pause reception enabled by auto-negotiation |
| rx_pause_vld | input | 1 | One-cycle strobe: a parsed pause frame is present |
| rx_pause_to_mcast | input | 1 | Frame destination is the reserved flow-control multicast |
| rx_pause_da_hit | input | 1 | Frame destination matched a programmed address |
| rx_pause_quanta | input | 16 | Pause quanta carried by the frame |
| reg_wr_en | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Live read of the control/status word |
| tx_hold | output | 1 | Hold-off request to the transmit MAC |

## Verification
The bench builds the block with its default parameters: a 16-bit counter inside a 32-bit word. Short quanta let whole intervals run to expiry in a few ticks. A manual load of 0xFFFF exercises the top of the count field and the abort path. With the full 16-bit width, every field position the requirements name is checked at the read port exactly as software would see it.

// File: rtl/pause_tmr_pkg.sv
// Shared field positions and types for the pause interval timer.
// Assumes a register word of at least CNT_LSB + counter width bits.
package pause_tmr_pkg;

    localparam int unsigned CTL_MAN_BIT  = 0;
    localparam int unsigned CTL_MC_BIT   = 1;
    localparam int unsigned CTL_DA_BIT   = 2;
    localparam int unsigned CTL_LOAD_BIT = 3;
    localparam int unsigned ST_ACT_BIT   = 8;
    localparam int unsigned ST_RCV_BIT   = 9;
    localparam int unsigned ST_NEG_BIT   = 10;
    localparam int unsigned CNT_LSB      = 16;

    typedef struct packed {
        logic man_en;
        logic mc_en;
        logic da_en;
    } pause_ctl_t;

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_CANCEL,
        EV_FRAME,
        EV_MLOAD,
        EV_TICK
    } pause_ev_e;

endpackage

// File: rtl/pause_cfg_regs.sv
// Control bits of the timer and decode of software writes.
// Produces the guarded-load request and the abort request; does not judge
// whether a load is allowed (the counter does that against its own flags).
module pause_cfg_regs
    import pause_tmr_pkg::*;
#(
    parameter int unsigned REG_W = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_man,
    input  logic             wr_mc,
    input  logic             wr_da,
    input  logic             wr_load,
    input  logic [CNT_W-1:0] wr_cnt,
    output pause_ctl_t       ctl,
    output logic             mload_req,
    output logic [CNT_W-1:0] load_val,
    output logic             cancel_req
);

    localparam int unsigned FIELD_END = CNT_LSB + CNT_W;

    initial begin
        if (FIELD_END > REG_W) $error("count field does not fit the word");
    end

    // Hold the enables written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_en) begin
            ctl.man_en <= wr_man;
            ctl.mc_en  <= wr_mc;
            ctl.da_en  <= wr_da;
        end
    end

    // Decode a manual load and an abort from the current write.
    always_comb begin
        mload_req  = wr_en & wr_load;
        load_val   = wr_cnt;
        cancel_req = wr_en & ctl.man_en & ~wr_man;
    end

endmodule

// File: rtl/pause_frame_qual.sv
// Decides whether a parsed pause frame is taken by the timer.
// Assumes frame parsing and address matching happened upstream.
module pause_frame_qual
    import pause_tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  pause_ctl_t       ctl,
    input  logic             neg_en,
    input  logic             vld,
    input  logic             to_mcast,
    input  logic             da_hit,
    input  logic [CNT_W-1:0] quanta,
    output logic             take,
    output logic [CNT_W-1:0] val
);

    logic rx_enabled;
    logic addr_ok;

    // Reception enable is the OR of the manual bit and negotiation.
    always_comb begin
        rx_enabled = ctl.man_en | neg_en;
        addr_ok    = (to_mcast & ctl.mc_en) | (da_hit & ctl.da_en);
        take       = vld & rx_enabled & addr_ok;
        val        = quanta;
    end

endmodule

// File: rtl/pause_count_unit.sv
// Pause interval counter with active and received flags.
// Event priority: abort, frame, guarded manual load, slot tick.
module pause_count_unit
    import pause_tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    input  logic             cancel_req,
    input  logic             frm_take,
    input  logic [CNT_W-1:0] frm_val,
    input  logic             mload_req,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             rcvd
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pause_ev_e ev;

    // Pick the single event that acts on this edge.
    always_comb begin
        if (cancel_req)                          ev = EV_CANCEL;
        else if (frm_take)                       ev = EV_FRAME;
        else if (mload_req && !active && !rcvd)  ev = EV_MLOAD;
        else if (slot_tick && active)            ev = EV_TICK;
        else                                     ev = EV_IDLE;
    end

    // Update count and flags according to the chosen event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
            rcvd   <= 1'b0;
        end else begin
            unique case (ev)
                EV_CANCEL: begin
                    cnt    <= '0;
                    active <= 1'b0;
                    rcvd   <= 1'b0;
                end
                EV_FRAME: begin
                    cnt    <= frm_val;
                    active <= |frm_val;
                    rcvd   <= |frm_val;
                end
                EV_MLOAD: begin
                    cnt    <= load_val;
                    active <= |load_val;
                    rcvd   <= 1'b0;
                end
                EV_TICK: begin
                    cnt <= cnt - ONE;
                    if (cnt == ONE) begin
                        active <= 1'b0;
                        rcvd   <= 1'b0;
                    end
                end
                default: begin
                    cnt <= cnt;
                end
            endcase
        end
    end

endmodule

// File: rtl/pause_timer_top.sv
// Transmit pause interval timer: takes qualified pause frames or manual
// loads, times them in slot ticks and holds off the transmit MAC.
// Assumes slot_tick is a one-cycle pulse in the clk domain.
module pause_timer_top
    import pause_tmr_pkg::*;
#(
    parameter int unsigned REG_W = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    input  logic             neg_en,
    input  logic             rx_pause_vld,
    input  logic             rx_pause_to_mcast,
    input  logic             rx_pause_da_hit,
    input  logic [CNT_W-1:0] rx_pause_quanta,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             tx_hold
);

    pause_ctl_t       ctl;
    logic             mload_req;
    logic [CNT_W-1:0] load_val;
    logic             cancel_req;
    logic             frm_take;
    logic [CNT_W-1:0] frm_val;
    logic [CNT_W-1:0] cnt_q;
    logic             act_q;
    logic             rcv_q;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[CNT_LSB-1:CTL_LOAD_BIT+1]};

    pause_cfg_regs #(.REG_W(REG_W), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_man     (reg_wdata[CTL_MAN_BIT]),
        .wr_mc      (reg_wdata[CTL_MC_BIT]),
        .wr_da      (reg_wdata[CTL_DA_BIT]),
        .wr_load    (reg_wdata[CTL_LOAD_BIT]),
        .wr_cnt     (reg_wdata[CNT_LSB +: CNT_W]),
        .ctl        (ctl),
        .mload_req  (mload_req),
        .load_val   (load_val),
        .cancel_req (cancel_req)
    );

    pause_frame_qual #(.CNT_W(CNT_W)) u_qual (
        .ctl      (ctl),
        .neg_en   (neg_en),
        .vld      (rx_pause_vld),
        .to_mcast (rx_pause_to_mcast),
        .da_hit   (rx_pause_da_hit),
        .quanta   (rx_pause_quanta),
        .take     (frm_take),
        .val      (frm_val)
    );

    pause_count_unit #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_tick  (slot_tick),
        .cancel_req (cancel_req),
        .frm_take   (frm_take),
        .frm_val    (frm_val),
        .mload_req  (mload_req),
        .load_val   (load_val),
        .cnt        (cnt_q),
        .active     (act_q),
        .rcvd       (rcv_q)
    );

    // Assemble the read word; load bit and spare bits read 0.
    always_comb begin
        reg_rdata                    = '0;
        reg_rdata[CTL_MAN_BIT]       = ctl.man_en;
        reg_rdata[CTL_MC_BIT]        = ctl.mc_en;
        reg_rdata[CTL_DA_BIT]        = ctl.da_en;
        reg_rdata[ST_ACT_BIT]        = act_q;
        reg_rdata[ST_RCV_BIT]        = rcv_q;
        reg_rdata[ST_NEG_BIT]        = neg_en;
        reg_rdata[CNT_LSB +: CNT_W]  = cnt_q;
        tx_hold                      = act_q;
    end

endmodule

// File: rtl/pause_timer_chk.sv
// Checker for the pause interval timer, bound into the top module.
module pause_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_tick,
    input logic             tx_hold,
    input logic [CNT_W-1:0] cnt,
    input logic             active,
    input logic             rcvd,
    input logic             frm_take,
    input logic [CNT_W-1:0] frm_val,
    input logic             mload_req,
    input logic [CNT_W-1:0] load_val,
    input logic             cancel_req
);

    a_r4_frame_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_take && frm_val != '0 && !cancel_req)
        |=> (active && rcvd && tx_hold && cnt == $past(frm_val)));

    a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (active && slot_tick && cnt > CNT_W'(1) && !frm_take && !mload_req && !cancel_req)
        |=> (cnt == $past(cnt) - CNT_W'(1)));

    a_r5_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_tick && !frm_take && !mload_req && !cancel_req) |=> $stable(cnt));

    a_r6_active_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt != '0));

    a_r6_rcvd_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        rcvd |-> active);

    a_r7_zero_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_take && frm_val == '0) |=> (!active && !rcvd && !tx_hold));

    a_r9_load_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (mload_req && (active || rcvd) && !frm_take && !cancel_req && !slot_tick)
        |=> $stable(cnt));

    a_r9_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (mload_req && !active && !rcvd && !frm_take && !cancel_req)
        |=> (!rcvd && cnt == $past(load_val)));

    a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_req |=> (!active && !rcvd && cnt == '0));

endmodule

bind pause_timer_top pause_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_tick  (slot_tick),
    .tx_hold    (tx_hold),
    .cnt        (cnt_q),
    .active     (act_q),
    .rcvd       (rcv_q),
    .frm_take   (frm_take),
    .frm_val    (frm_val),
    .mload_req  (mload_req),
    .load_val   (load_val),
    .cancel_req (cancel_req)
);

// File: tb/pause_timer_top_tb.sv
module pause_timer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_tick = 1'b0;
    logic        neg_en = 1'b0;
    logic        rx_pause_vld = 1'b0;
    logic        rx_pause_to_mcast = 1'b0;
    logic        rx_pause_da_hit = 1'b0;
    logic [15:0] rx_pause_quanta = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_hold;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pause_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .neg_en(neg_en),
        .rx_pause_vld(rx_pause_vld), .rx_pause_to_mcast(rx_pause_to_mcast),
        .rx_pause_da_hit(rx_pause_da_hit), .rx_pause_quanta(rx_pause_quanta),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_hold(tx_hold)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Check count, active, received and tx_hold together.
    task automatic chk_state(input string tag, input logic [15:0] c, input logic a, input logic r);
        chk({tag, " count"}, 32'(reg_rdata[31:16]), 32'(c));
        chk({tag, " active"}, 32'(reg_rdata[8]), 32'(a));
        chk({tag, " received"}, 32'(reg_rdata[9]), 32'(r));
        chk({tag, " tx_hold"}, 32'(tx_hold), 32'(a));
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic frame(input logic [15:0] q, input logic mc, input logic da);
        rx_pause_vld = 1'b1; rx_pause_quanta = q;
        rx_pause_to_mcast = mc; rx_pause_da_hit = da;
        @(negedge clk);
        rx_pause_vld = 1'b0; rx_pause_quanta = '0;
        rx_pause_to_mcast = 1'b0; rx_pause_da_hit = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            slot_tick = 1'b1;
            @(negedge clk);
            slot_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 read word", reg_rdata, 32'h0);
        chk("R1 tx_hold", 32'(tx_hold), 32'h0);
    endtask

    task automatic t_enable;
        wr(32'h2);
        frame(16'd10, 1'b1, 1'b0);
        chk_state("R2 disabled frame", 16'd0, 1'b0, 1'b0);
        neg_en = 1'b1;
        @(negedge clk);
        chk("R10 neg bit", 32'(reg_rdata[10]), 32'h1);
        frame(16'd10, 1'b1, 1'b0);
        chk_state("R2 R4 negotiated frame", 16'd10, 1'b1, 1'b1);
        ticks(10);
        chk_state("R6 expiry", 16'd0, 1'b0, 1'b0);
        neg_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_qual;
        wr(32'h3);
        chk("R10 enables readback", 32'(reg_rdata[2:0]), 32'h3);
        frame(16'd7, 1'b0, 1'b1);
        chk_state("R3 da hit without da enable", 16'd0, 1'b0, 1'b0);
        wr(32'h5);
        frame(16'd7, 1'b1, 1'b0);
        chk_state("R3 mcast without mc enable", 16'd0, 1'b0, 1'b0);
        frame(16'd7, 1'b0, 1'b1);
        chk_state("R3 da hit taken", 16'd7, 1'b1, 1'b1);
        frame(16'd0, 1'b0, 1'b1);
        chk_state("R7 zero quanta", 16'd0, 1'b0, 1'b0);
    endtask

    task automatic t_count;
        frame(16'd3, 1'b0, 1'b1);
        idle(5);
        chk_state("R5 hold without tick", 16'd3, 1'b1, 1'b1);
        ticks(2);
        chk_state("R5 two ticks", 16'd1, 1'b1, 1'b1);
        ticks(1);
        chk_state("R6 last tick", 16'd0, 1'b0, 1'b0);
    endtask

    task automatic t_reload;
        frame(16'd20, 1'b0, 1'b1);
        ticks(5);
        chk_state("R5 after five ticks", 16'd15, 1'b1, 1'b1);
        frame(16'd9, 1'b0, 1'b1);
        chk_state("R8 reload", 16'd9, 1'b1, 1'b1);
        frame(16'd0, 1'b0, 1'b1);
        chk_state("R7 zero ends reload", 16'd0, 1'b0, 1'b0);
    endtask

    task automatic t_manual;
        wr({16'd4, 16'h000D});
        chk_state("R9 manual load", 16'd4, 1'b1, 1'b0);
        chk("R10 load bit reads 0", 32'(reg_rdata[3]), 32'h0);
        wr({16'h0050, 16'h000D});
        chk_state("R9 load refused while active", 16'd4, 1'b1, 1'b0);
        ticks(4);
        chk_state("R6 manual expiry", 16'd0, 1'b0, 1'b0);
        frame(16'd6, 1'b0, 1'b1);
        wr({16'h0022, 16'h000D});
        chk_state("R9 load refused while received", 16'd6, 1'b1, 1'b1);
        frame(16'd0, 1'b0, 1'b1);
        wr({16'hFFFF, 16'h000D});
        chk_state("R9 full-scale load", 16'hFFFF, 1'b1, 1'b0);
    endtask

    task automatic t_abort;
        wr(32'h5);
        chk_state("R11 keep enable no abort", 16'hFFFF, 1'b1, 1'b0);
        wr(32'h4);
        chk_state("R11 clear enable aborts", 16'd0, 1'b0, 1'b0);
        frame(16'd8, 1'b0, 1'b1);
        chk_state("R2 frame after disable", 16'd0, 1'b0, 1'b0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_qual();
        t_count();
        t_reload();
        t_manual();
        t_abort();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule